// File: doc/BRIEF.md
# List Register Maintenance Status Generator

This block watches the live contents of a virtual interrupt controller's list registers and turns them into the status that a hypervisor uses for maintenance. Each list entry supplies a 2-bit lifecycle state, a hardware-linked bit and a request-notify-on-completion bit. From these, the block builds two per-entry vectors. The first marks entries that have completed and asked for notification. The second marks entries that are free for reuse.

A second stage combines the scan results with the hypervisor's interrupt enables and the guest's two virtual group enables. It produces an 8-bit maintenance status word. When the global control enable is set and any bit of that word is set, the block raises a single maintenance interrupt line.

All outputs are registered. They show the inputs that were present at the previous rising clock edge. The list register storage sits outside this block and feeds it directly.

Top module: `lr_maint_status`

## Requirements
- R1: While `rst_n` is low, every output is 0, whatever the inputs are.
- R2: Bit i of `eoiStatus` is 1 exactly when entry i has state 00, hardware bit 0 and notify bit 1.
- R3: Bit i of `emptyStatus` is 1 exactly when entry i has state 00 and either its hardware bit is 1 or its notify bit is 0. An entry whose state is nonzero has both of its status bits at 0.
- R4: Bit 0 of `maintWord` is the OR of all `eoiStatus` bits.
- R5: Bit 1 of `maintWord` is 1 when `underflowIe` is 1 and fewer than two entries have a nonzero state.
- R6: Bit 2 of `maintWord` is 1 when `entryMissIe` is 1 or `eoiCount` is nonzero.
- R7: Bit 3 of `maintWord` is 1 when `noPendIe` is 1 and no entry has state 01 (pending). State 11 (pending and active) does not count as pending.
- R8: Bit 4 of `maintWord` is `grp0OnIe` AND `vGrp0En`. Bit 6 is `grp1OnIe` AND `vGrp1En`.
- R9: Bit 5 of `maintWord` is `grp0OffIe` AND NOT `vGrp0En`. Bit 7 is `grp1OffIe` AND NOT `vGrp1En`.
- R10: `maintIrq` is 1 exactly when `ctlEn` is 1 and `maintWord` is nonzero, with both taken from the same input cycle.
- R11: Every output reflects the inputs sampled at the previous rising clock edge, which is a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lrState | input | 2*NUM_LR | State of each entry. Entry i uses bits [2i+1:2i]. 00 = invalid, 01 = pending, 10 = active, 11 = pending and active |
| lrHw | input | NUM_LR | Hardware-linked bit of each entry |
| lrEoi | input | NUM_LR | Notify-on-completion bit of each entry |
| ctlEn | input | 1 | Global control enable that gates `maintIrq` |
| underflowIe | input | 1 | Enable for the underflow status bit |
| entryMissIe | input | 1 | Enable for the entry-not-present status bit |
| noPendIe | input | 1 | Enable for the no-pending status bit |
| grp0OnIe | input | 1 | Enable for the group-0-enabled status bit |
| grp0OffIe | input | 1 | Enable for the group-0-disabled status bit |
| grp1OnIe | input | 1 | Enable for the group-1-enabled status bit |
| grp1OffIe | input | 1 | Enable for the group-1-disabled status bit |
| eoiCount | input | EOICNT_W | Count of completions that did not match any entry |
| vGrp0En | input | 1 | Guest virtual group 0 enable |
| vGrp1En | input | 1 | Guest virtual group 1 enable |
| eoiStatus | output | NUM_LR | Per-entry completed-with-notify status |
| emptyStatus | output | NUM_LR | Per-entry free status |
| maintWord | output | 8 | Maintenance status word, bit layout as in R4 to R9 |
| maintIrq | output | 1 | Maintenance interrupt |

## Verification
The hardest conditions to reach are the thresholds of the entry scan. The underflow bit must be seen to flip exactly between one and two valid entries. The no-pending bit must stay set when the only pending-looking entries use state 11. It must also react to a single pending entry in the highest slot. Random stimulus over 16 entries almost never leaves fewer than two valid entries, so directed vectors walk the valid count through 0, 1 and 2 at both ends of the array. They also place lone pending and pending-active entries in the highest slot. Only after that does a long random run with biased state fields cover the rest of the input space.

// File: rtl/lrm_pkg.sv
package lrm_pkg;

  typedef enum logic [1:0] {
    LR_INVALID  = 2'b00,
    LR_PENDING  = 2'b01,
    LR_ACTIVE   = 2'b10,
    LR_PEND_ACT = 2'b11
  } lrState_e;

  // Bit positions inside the maintenance status word
  localparam int MW_EOI    = 0;
  localparam int MW_UNDER  = 1;
  localparam int MW_LRENP  = 2;
  localparam int MW_NOPEND = 3;
  localparam int MW_G0ON   = 4;
  localparam int MW_G0OFF  = 5;
  localparam int MW_G1ON   = 6;
  localparam int MW_G1OFF  = 7;
  localparam int MW_WIDTH  = 8;

  // Strobes from the entry scan to the control stage
  typedef struct packed {
    logic anyEoi;
    logic fewValid;
    logic nonePending;
  } scanSum_t;

endpackage

// File: rtl/lrm_scan.sv
module lrm_scan
  import lrm_pkg::*;
#(
  parameter int NUM_LR = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*NUM_LR-1:0] lrState,
  input  logic [NUM_LR-1:0]   lrHw,
  input  logic [NUM_LR-1:0]   lrEoi,
  output logic [NUM_LR-1:0]   eoiStatus,
  output logic [NUM_LR-1:0]   emptyStatus,
  output scanSum_t            scanSum
);

  localparam int CNT_W = $clog2(NUM_LR + 1);

  logic [NUM_LR-1:0] stateZero;
  logic [NUM_LR-1:0] isPending;
  logic [NUM_LR-1:0] eoiNext;
  logic [NUM_LR-1:0] emptyNext;
  logic [CNT_W-1:0]  validCnt;

  for (genvar i = 0; i < NUM_LR; i++) begin : g_entry
    lrState_e st;
    assign st           = lrState_e'(lrState[2*i +: 2]);
    assign stateZero[i] = (st == LR_INVALID);
    assign isPending[i] = (st == LR_PENDING);
    assign eoiNext[i]   = stateZero[i] && !lrHw[i] && lrEoi[i];
    assign emptyNext[i] = stateZero[i] && (lrHw[i] || !lrEoi[i]);

    // R2/R3: the two per-entry flags exclude each other
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      eoiStatus[i] |-> !emptyStatus[i]);
    // R3: an occupied entry reports neither completion nor free
    a_r3_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (lrState[2*i +: 2] != 2'b00) |=> (!eoiStatus[i] && !emptyStatus[i]));
  end

  always_comb begin
    validCnt = '0;
    for (int i = 0; i < NUM_LR; i++) begin
      validCnt = validCnt + CNT_W'(!stateZero[i]);
    end
  end

  assign scanSum.anyEoi      = |eoiNext;
  assign scanSum.fewValid    = (validCnt < CNT_W'(2));
  assign scanSum.nonePending = ~|isPending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoiStatus   <= '0;
      emptyStatus <= '0;
    end else begin
      eoiStatus   <= eoiNext;
      emptyStatus <= emptyNext;
    end
  end

endmodule

// File: rtl/lrm_ctrl.sv
module lrm_ctrl
  import lrm_pkg::*;
#(
  parameter int EOICNT_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  scanSum_t            scanSum,
  input  logic                ctlEn,
  input  logic                underflowIe,
  input  logic                entryMissIe,
  input  logic                noPendIe,
  input  logic                grp0OnIe,
  input  logic                grp0OffIe,
  input  logic                grp1OnIe,
  input  logic                grp1OffIe,
  input  logic [EOICNT_W-1:0] eoiCount,
  input  logic                vGrp0En,
  input  logic                vGrp1En,
  output logic [MW_WIDTH-1:0] maintWord,
  output logic                maintIrq
);

  logic [MW_WIDTH-1:0] wordNext;

  always_comb begin
    wordNext            = '0;
    wordNext[MW_EOI]    = scanSum.anyEoi;
    wordNext[MW_UNDER]  = underflowIe && scanSum.fewValid;
    wordNext[MW_LRENP]  = entryMissIe || (eoiCount != '0);
    wordNext[MW_NOPEND] = noPendIe && scanSum.nonePending;
    wordNext[MW_G0ON]   = grp0OnIe && vGrp0En;
    wordNext[MW_G0OFF]  = grp0OffIe && !vGrp0En;
    wordNext[MW_G1ON]   = grp1OnIe && vGrp1En;
    wordNext[MW_G1OFF]  = grp1OffIe && !vGrp1En;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maintWord <= '0;
      maintIrq  <= 1'b0;
    end else begin
      maintWord <= wordNext;
      maintIrq  <= ctlEn && (|wordNext);
    end
  end

  // R10: no interrupt without the control enable
  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !ctlEn |=> !maintIrq);
  // R10: an interrupt always has a visible cause
  a_r10_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    maintIrq |-> (maintWord != '0));
  // R6: a nonzero unmatched-completion count forces the not-present bit
  a_r6_count_forces: assert property (@(posedge clk) disable iff (!rst_n)
    (eoiCount != '0) |=> maintWord[MW_LRENP]);
  // R9: a disabled group-off enable keeps its bit clear
  a_r9_g0off_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !grp0OffIe |=> !maintWord[MW_G0OFF]);
  // R5: a disabled underflow enable keeps its bit clear
  a_r5_under_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !underflowIe |=> !maintWord[MW_UNDER]);

endmodule

// File: rtl/lr_maint_status.sv
module lr_maint_status
  import lrm_pkg::*;
#(
  parameter int NUM_LR   = 16,
  parameter int EOICNT_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*NUM_LR-1:0] lrState,
  input  logic [NUM_LR-1:0]   lrHw,
  input  logic [NUM_LR-1:0]   lrEoi,
  input  logic                ctlEn,
  input  logic                underflowIe,
  input  logic                entryMissIe,
  input  logic                noPendIe,
  input  logic                grp0OnIe,
  input  logic                grp0OffIe,
  input  logic                grp1OnIe,
  input  logic                grp1OffIe,
  input  logic [EOICNT_W-1:0] eoiCount,
  input  logic                vGrp0En,
  input  logic                vGrp1En,
  output logic [NUM_LR-1:0]   eoiStatus,
  output logic [NUM_LR-1:0]   emptyStatus,
  output logic [7:0]          maintWord,
  output logic                maintIrq
);

  scanSum_t scanSum;

  lrm_scan #(.NUM_LR(NUM_LR)) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .lrState     (lrState),
    .lrHw        (lrHw),
    .lrEoi       (lrEoi),
    .eoiStatus   (eoiStatus),
    .emptyStatus (emptyStatus),
    .scanSum     (scanSum)
  );

  lrm_ctrl #(.EOICNT_W(EOICNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .scanSum     (scanSum),
    .ctlEn       (ctlEn),
    .underflowIe (underflowIe),
    .entryMissIe (entryMissIe),
    .noPendIe    (noPendIe),
    .grp0OnIe    (grp0OnIe),
    .grp0OffIe   (grp0OffIe),
    .grp1OnIe    (grp1OnIe),
    .grp1OffIe   (grp1OffIe),
    .eoiCount    (eoiCount),
    .vGrp0En     (vGrp0En),
    .vGrp1En     (vGrp1En),
    .maintWord   (maintWord),
    .maintIrq    (maintIrq)
  );

  // R4: the summary bit agrees with the per-entry vector of the other stage
  a_r4_eoi_summary: assert property (@(posedge clk) disable iff (!rst_n)
    maintWord[MW_EOI] == (|eoiStatus));

endmodule

// File: tb/test_lr_maint_status.sv
module test_lr_maint_status;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_LR     = 16;
  localparam int EOICNT_W   = 5;

  typedef struct packed {
    logic [NUM_LR-1:0] eoi;
    logic [NUM_LR-1:0] empty;
    logic [7:0]        word;
    logic              irq;
  } expItem_t;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [2*NUM_LR-1:0] lrState = '0;
  logic [NUM_LR-1:0]   lrHw = '0;
  logic [NUM_LR-1:0]   lrEoi = '0;
  logic                ctlEn = 1'b0;
  logic [6:0]          ies = '0;   // underflow, miss, nopend, g0on, g0off, g1on, g1off
  logic [EOICNT_W-1:0] eoiCount = '0;
  logic                vGrp0En = 1'b0;
  logic                vGrp1En = 1'b0;
  logic [NUM_LR-1:0]   eoiStatus;
  logic [NUM_LR-1:0]   emptyStatus;
  logic [7:0]          maintWord;
  logic                maintIrq;

  int       nChecks = 0;
  int       nFails  = 0;
  expItem_t expQ[$];
  bit       driveDone = 1'b0;
  string    wordTag [0:7] = '{"R4", "R5", "R6", "R7", "R8", "R9", "R8", "R9"};

  always #(CLK_PERIOD/2) clk = ~clk;

  lr_maint_status #(.NUM_LR(NUM_LR), .EOICNT_W(EOICNT_W)) i_lr_maint_status (
    .clk(clk), .rst_n(rst_n), .lrState(lrState), .lrHw(lrHw), .lrEoi(lrEoi),
    .ctlEn(ctlEn), .underflowIe(ies[0]), .entryMissIe(ies[1]), .noPendIe(ies[2]),
    .grp0OnIe(ies[3]), .grp0OffIe(ies[4]), .grp1OnIe(ies[5]), .grp1OffIe(ies[6]),
    .eoiCount(eoiCount), .vGrp0En(vGrp0En), .vGrp1En(vGrp1En),
    .eoiStatus(eoiStatus), .emptyStatus(emptyStatus),
    .maintWord(maintWord), .maintIrq(maintIrq)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Reference built from the requirement text
  function automatic expItem_t model();
    expItem_t e;
    int nValid = 0;
    bit anyPend = 0;
    e = '0;
    for (int i = 0; i < NUM_LR; i++) begin
      logic [1:0] s = lrState[2*i +: 2];
      e.eoi[i]   = (s == 2'b00) && !lrHw[i] && lrEoi[i];
      e.empty[i] = (s == 2'b00) && (lrHw[i] || !lrEoi[i]);
      if (s != 2'b00) nValid++;
      if (s == 2'b01) anyPend = 1;
    end
    e.word[0] = |e.eoi;
    e.word[1] = ies[0] && (nValid < 2);
    e.word[2] = ies[1] || (eoiCount != 0);
    e.word[3] = ies[2] && !anyPend;
    e.word[4] = ies[3] && vGrp0En;
    e.word[5] = ies[4] && !vGrp0En;
    e.word[6] = ies[5] && vGrp1En;
    e.word[7] = ies[6] && !vGrp1En;
    e.irq     = ctlEn && (e.word != 0);
    return e;
  endfunction

  task automatic drive(logic [2*NUM_LR-1:0] st, logic [NUM_LR-1:0] hw,
                       logic [NUM_LR-1:0] eo, logic ce, logic [6:0] ie,
                       logic [EOICNT_W-1:0] cnt, logic g0, logic g1);
    @(negedge clk);
    lrState = st; lrHw = hw; lrEoi = eo; ctlEn = ce; ies = ie;
    eoiCount = cnt; vGrp0En = g0; vGrp1En = g1;
    expQ.push_back(model());
  endtask

  // Monitor: R11, each pushed item appears after the next rising edge
  initial begin
    expItem_t e;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        check("R2", 32'(eoiStatus), 32'(e.eoi));
        check("R3", 32'(emptyStatus), 32'(e.empty));
        for (int b = 0; b < 8; b++) check(wordTag[b], 32'(maintWord[b]), 32'(e.word[b]));
        check("R10", 32'(maintIrq), 32'(e.irq));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: outputs stay zero while reset is held, even with busy inputs
    lrState = '0; lrHw = '0; lrEoi = '1; ctlEn = 1'b1; ies = '1; eoiCount = 5'd3;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1", 32'(eoiStatus), 32'h0);
    check("R1", 32'(emptyStatus), 32'h0);
    check("R1", 32'(maintWord), 32'h0);
    check("R1", 32'(maintIrq), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // all idle, no enables: every entry free (R3), nothing raised
    drive('0, '0, '0, 1'b1, 7'h00, '0, 1'b0, 1'b0);
    // all entries completed with notify, all enables (R2, R4, R5, R7)
    drive('0, '0, '1, 1'b1, 7'h7f, '0, 1'b1, 1'b0);
    // hardware-linked completed entries are free, not notifying (R3)
    drive('0, '1, '1, 1'b1, 7'h01, '0, 1'b0, 1'b1);
    // valid count thresholds for R5: one valid at entry 15, then two
    drive({2'b10, 30'b0}, '0, '0, 1'b1, 7'h01, '0, 1'b0, 1'b0);
    drive({2'b10, 28'b0, 2'b11}, '0, '0, 1'b1, 7'h01, '0, 1'b0, 1'b0);
    drive({2'b00, 28'b0, 2'b01}, '0, '0, 1'b1, 7'h01, '0, 1'b0, 1'b0);
    // R7: state 11 is not pending, lone pending in highest slot is
    drive({2'b11, 28'b0, 2'b11}, '0, '0, 1'b1, 7'h04, '0, 1'b0, 1'b0);
    drive({2'b01, 28'b0, 2'b10}, '0, '0, 1'b1, 7'h04, '0, 1'b0, 1'b0);
    // R6: count alone, enable alone
    drive({NUM_LR{2'b10}}, '0, '0, 1'b1, 7'h00, 5'd1, 1'b0, 1'b0);
    drive({NUM_LR{2'b10}}, '0, '0, 1'b0, 7'h02, 5'd0, 1'b0, 1'b0);
    // R8/R9: group enable combinations
    for (int g = 0; g < 4; g++) begin
      drive({NUM_LR{2'b10}}, '0, '0, 1'b1, 7'h78, '0, g[0], g[1]);
    end
    // R10: causes present but control disabled
    drive('0, '0, '1, 1'b0, 7'h7f, 5'd7, 1'b0, 1'b0);

    // random run with biased state fields
    for (int n = 0; n < 400; n++) begin
      logic [2*NUM_LR-1:0] st;
      for (int i = 0; i < NUM_LR; i++) begin
        st[2*i +: 2] = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
      end
      if (n % 3 == 0) st = 2*NUM_LR'($urandom) & {{(2*NUM_LR-4){1'b0}}, 4'hf};
      drive(st, NUM_LR'($urandom), NUM_LR'($urandom), 1'($urandom),
            7'($urandom), ($urandom_range(0, 3) == 0) ? EOICNT_W'($urandom) : '0,
            1'($urandom), 1'($urandom));
    end

    @(negedge clk);
    @(negedge clk);
    driveDone = 1'b1;
    if (expQ.size() != 0) check("R11", 32'(expQ.size()), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule